// File: doc/BRIEF.md
# Video DMA Engine with CPU Stall

This block copies a run of 16-bit words from a CPU-side memory into video RAM. Software sets a word count, a 24-bit source byte address and a destination step through single-word register writes. It then issues a two-word start command. The first command word loads the video RAM destination address and arms the engine. When the second word is accepted with its start bit set, the transfer begins on the next clock.

From that cycle the CPU bus is held in a wait state. The rest of the system keeps running. The engine moves one word in every cycle in which the video memory arbiter grants it an access slot. Any CPU write that arrives while the engine is busy stays on the bus and is not accepted. This includes the second half of a 32-bit access whose first half started the transfer. The held write lands only when the wait state ends, so a held write to the length register affects only the next transfer.

A length of zero moves the full 65536 words.

Top module: `vdma_stall_ctrl`

## Requirements
- R1: After reset, cpu_wait, dma_busy and vram_we are all low.
- R2: Select codes are 0 length, 1 source bits [15:0], 2 source bits [23:16] (data bits [7:0]), 3 destination step (data bits [7:0]), 4 command word A (destination address) and 5 command word B (start when data bit 0 is 1). An accepted B write with bit 0 set, after an A write with no B write between them, raises cpu_wait and dma_busy from the next cycle. A B write with bit 0 clear, or a B write with no A write since the previous B, starts nothing.
- R3: During a transfer, vram_we is high in exactly the cycles where slot_grant is high, and it is never high at any other time.
- R4: vram_addr starts at the command word A value and advances by the step, modulo 65536. src_addr starts at the programmed source address, advances by 2 per word, and continues from where the previous transfer ended. vram_wdata equals src_rdata in the same cycle.
- R5: A transfer moves exactly as many words as the length register holds, and a length of 0 moves 65536 words.
- R6: cpu_wait stays high through the cycle of the final word and the cycle after it, and is low in the second cycle after the final word.
- R7: A write presented while cpu_wait is high is not accepted. The CPU keeps it on the bus, and it takes effect at the edge that ends the first cycle with cpu_wait low. A held length write sets only the next transfer's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write request, held until accepted |
| cpu_sel | input | 3 | Register select |
| cpu_wdata | input | 16 | CPU write data |
| cpu_wait | output | 1 | Bus wait state; a write is accepted only while this is low |
| dma_busy | output | 1 | Status: high while a transfer is in progress |
| slot_grant | input | 1 | Video memory access slot granted to DMA this cycle |
| src_addr | output | 24 | Source byte address of the current word |
| src_rdata | input | 16 | Source word read combinationally at src_addr |
| vram_we | output | 1 | Video RAM write strobe |
| vram_addr | output | 16 | Video RAM byte address |
| vram_wdata | output | 16 | Video RAM write data |

## Verification
Transfers run with three slot patterns, each showing something different:
- An irregular pseudo-random pattern shows that words move only in granted cycles, whatever the gaps between grants.
- A sparse pattern of one grant every third cycle separates the release timing from the grant rhythm.
- An always-granted pattern drives the zero-length case through all 65536 words.

A 32-bit style write pair, whose second half targets the length register, shows that the old length finishes the current transfer and the new one governs the next. The destination address also wraps past 0xFFFF in this case.

Start commands that lack the arming write or the start bit separate the two-word command sequence from a single register write.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_DRAIN = 2'd2
    } xfer_state_e;

    localparam logic [2:0] SEL_LEN    = 3'd0;
    localparam logic [2:0] SEL_SRC_LO = 3'd1;
    localparam logic [2:0] SEL_SRC_HI = 3'd2;
    localparam logic [2:0] SEL_STEP   = 3'd3;
    localparam logic [2:0] SEL_CMD_A  = 3'd4;
    localparam logic [2:0] SEL_CMD_B  = 3'd5;

    localparam int GO_BIT = 0;

endpackage

// File: rtl/vdma_regs.sv
module vdma_regs #(
    parameter int DW     = 16,
    parameter int LEN_W  = 16,
    parameter int SRC_AW = 24,
    parameter int DST_AW = 16,
    parameter int INC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        sel,
    input  logic [DW-1:0]     wdata,
    input  logic              step,
    output logic              trigger,
    output logic              last,
    output logic [SRC_AW-1:0] src_q,
    output logic [DST_AW-1:0] dst_q
);
    import vdma_pkg::*;

    localparam int SRC_HI_W = SRC_AW - DW;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [SRC_AW-1:0] src;
        logic [DST_AW-1:0] dst;
        logic [INC_W-1:0]  inc;
        logic              armed;
    } regs_t;

    regs_t r_q, r_d;
    logic  trig_d;
    logic  unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        r_d    = r_q;
        trig_d = 1'b0;
        if (step) begin
            r_d.len = r_q.len - LEN_W'(1);
            r_d.src = r_q.src + SRC_AW'(2);
            r_d.dst = r_q.dst + DST_AW'(r_q.inc);
        end else if (wr_en) begin
            case (sel)
                SEL_LEN:    r_d.len = LEN_W'(wdata);
                SEL_SRC_LO: r_d.src[DW-1:0] = wdata;
                SEL_SRC_HI: r_d.src[SRC_AW-1:DW] = wdata[SRC_HI_W-1:0];
                SEL_STEP:   r_d.inc = wdata[INC_W-1:0];
                SEL_CMD_A: begin
                    r_d.dst   = DST_AW'(wdata);
                    r_d.armed = 1'b1;
                end
                SEL_CMD_B: begin
                    trig_d    = r_q.armed && wdata[GO_BIT];
                    r_d.armed = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign trigger = trig_d;
    assign last    = (r_q.len == LEN_W'(1));
    assign src_q   = r_q.src;
    assign dst_q   = r_q.dst;

    // R5: counter drops by one per moved word
    a_r5_len_dec: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (r_q.len == $past(r_q.len) - LEN_W'(1)));

    // R4: source advances two bytes per word
    a_r4_src_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (r_q.src == $past(r_q.src) + SRC_AW'(2)));

    // R7: without an accepted write or a move, nothing changes
    a_r7_hold_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !step) |=> $stable(r_q));

endmodule

// File: rtl/vdma_fsm.sv
module vdma_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic grant,
    input  logic last,
    output logic step,
    output logic busy
);
    import vdma_pkg::*;

    typedef struct packed {
        xfer_state_e state;
    } fsm_t;

    fsm_t f_q, f_d;

    always_comb begin
        f_d = f_q;
        case (f_q.state)
            ST_IDLE:  if (trigger) f_d.state = ST_XFER;
            ST_XFER:  if (grant && last) f_d.state = ST_DRAIN;
            ST_DRAIN: f_d.state = ST_IDLE;
            default:  f_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q.state <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign step = (f_q.state == ST_XFER) && grant;
    assign busy = (f_q.state != ST_IDLE);

    // R2: a start in idle stalls from the next cycle
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trigger) |=> (f_q.state == ST_XFER));

    // R6: final word leads to exactly one drain cycle
    a_r6_last: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> (f_q.state == ST_DRAIN));

    a_r6_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.state == ST_DRAIN) |=> !busy);

endmodule

// File: rtl/vdma_stall_ctrl.sv
module vdma_stall_ctrl #(
    parameter int DW     = 16,
    parameter int LEN_W  = 16,
    parameter int SRC_AW = 24,
    parameter int DST_AW = 16,
    parameter int INC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [2:0]        cpu_sel,
    input  logic [DW-1:0]     cpu_wdata,
    output logic              cpu_wait,
    output logic              dma_busy,
    input  logic              slot_grant,
    output logic [SRC_AW-1:0] src_addr,
    input  logic [DW-1:0]     src_rdata,
    output logic              vram_we,
    output logic [DST_AW-1:0] vram_addr,
    output logic [DW-1:0]     vram_wdata
);
    logic busy;
    logic wr_en;
    logic step;
    logic trigger;
    logic last;

    assign wr_en = cpu_wr && !busy;

    vdma_regs #(
        .DW(DW), .LEN_W(LEN_W), .SRC_AW(SRC_AW), .DST_AW(DST_AW), .INC_W(INC_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (cpu_sel),
        .wdata   (cpu_wdata),
        .step    (step),
        .trigger (trigger),
        .last    (last),
        .src_q   (src_addr),
        .dst_q   (vram_addr)
    );

    vdma_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (trigger),
        .grant   (slot_grant),
        .last    (last),
        .step    (step),
        .busy    (busy)
    );

    assign cpu_wait   = busy;
    assign dma_busy   = busy;
    assign vram_we    = step;
    assign vram_wdata = src_rdata;

    // R3: video writes only in granted cycles of a transfer
    a_r3_we_grant: assert property (@(posedge clk) disable iff (!rst_n)
        vram_we |-> (slot_grant && cpu_wait));

    // R4: destination holds still between moves while busy
    a_r4_dst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wait && !vram_we) |=> $stable(vram_addr));

endmodule

// File: tb/vdma_stall_ctrl_tb.sv
module vdma_stall_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [2:0]  cpu_sel = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_wait, dma_busy;
    logic        slot_grant = 1'b0;
    logic [23:0] src_addr;
    logic [15:0] src_rdata;
    logic        vram_we;
    logic [15:0] vram_addr, vram_wdata;

    always #2.5ns clk = ~clk;

    vdma_stall_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .cpu_wait(cpu_wait), .dma_busy(dma_busy),
        .slot_grant(slot_grant), .src_addr(src_addr), .src_rdata(src_rdata),
        .vram_we(vram_we), .vram_addr(vram_addr), .vram_wdata(vram_wdata)
    );

    function automatic logic [15:0] mem_word(input logic [23:0] a);
        return a[16:1] ^ 16'h5A3C ^ {a[23:17], 9'd0};
    endfunction

    assign src_rdata = mem_word(src_addr);

    typedef struct { logic [15:0] a; logic [15:0] d; } exp_t;
    exp_t q_exp[$];

    int n_cmp = 0, n_fail = 0;
    int pcyc = 0, last_we = 0, we_cnt = 0;
    int gmode = 0;
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [23:0] m_src;
    logic [15:0] m_dst;
    logic [7:0]  m_inc;

    always @(posedge clk) pcyc <= pcyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // slot grant driver
    initial forever begin
        @(posedge clk); #1ns;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (gmode)
            0: slot_grant = 1'b1;
            1: slot_grant = lfsr[0] ^ lfsr[5];
            default: slot_grant = (pcyc % 3 == 0);
        endcase
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && vram_we) begin
            last_we = pcyc;
            we_cnt++;
            if (!slot_grant) check(0, "R3", "write without grant", 0, 1);
            if (q_exp.size() == 0) begin
                check(0, "R3", "unexpected vram write", vram_addr, 0);
            end else begin
                exp_t e;
                e = q_exp.pop_front();
                check(vram_addr == e.a && vram_wdata == e.d, "R4", "addr/data",
                      {vram_addr, vram_wdata}, {e.a, e.d});
            end
        end
    end

    task automatic cpu_write(input logic [2:0] sel, input logic [15:0] data,
                             output bit first_wait, output int acc_cyc);
        bit acc;
        bit first = 1;
        cpu_wr = 1'b1; cpu_sel = sel; cpu_wdata = data;
        do begin
            @(negedge clk);
            acc = !cpu_wait;
            acc_cyc = pcyc;
            if (first) first_wait = cpu_wait;
            first = 0;
            @(posedge clk); #1ns;
        end while (!acc);
        cpu_wr = 1'b0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        bit fw; int c;
        cpu_write(sel, data, fw, c);
        if (sel == 3'd1) m_src[15:0] = data;
        if (sel == 3'd2) m_src[23:16] = data[7:0];
        if (sel == 3'd3) m_inc = data[7:0];
    endtask

    task automatic push_exp(input int words, input logic [15:0] dst);
        m_dst = dst;
        for (int i = 0; i < words; i++) begin
            exp_t e;
            e.a = m_dst; e.d = mem_word(m_src);
            q_exp.push_back(e);
            m_src = m_src + 24'd2;
            m_dst = m_dst + 16'(m_inc);
        end
    endtask

    task automatic finish_check(input int words, input int we0, input string tag);
        int t;
        @(negedge clk);
        while (cpu_wait) @(negedge clk);
        t = pcyc;
        check(t == last_we + 2, "R6", {tag, " release cycle"}, t - last_we, 2);
        check(we_cnt - we0 == words, "R5", {tag, " word count"}, we_cnt - we0, words);
        check(q_exp.size() == 0, "R5", {tag, " leftover expected"}, q_exp.size(), 0);
    endtask

    task automatic run_dma(input int words, input logic [15:0] dst, input string tag);
        int we0;
        push_exp(words, dst);
        we0 = we_cnt;
        wr(3'd4, dst);
        wr(3'd5, 16'h0001);
        @(negedge clk);
        check(cpu_wait && dma_busy, "R2", {tag, " stall on trigger"}, cpu_wait, 1);
        finish_check(words, we0, tag);
    endtask

    task automatic idle_window(input string tag);
        int we0 = we_cnt;
        repeat (8) begin
            @(negedge clk);
            check(!cpu_wait && !dma_busy, "R2", tag, cpu_wait, 0);
        end
        check(we_cnt == we0, "R2", {tag, " no words"}, we_cnt - we0, 0);
    endtask

    initial begin
        int we0, acc_c;
        bit fw;
        m_src = '0; m_dst = '0; m_inc = '0;
        repeat (4) @(posedge clk);
        #1ns rst_n = 1'b1;
        @(negedge clk);
        check(!cpu_wait && !dma_busy && !vram_we, "R1", "reset outputs",
              {cpu_wait, dma_busy, vram_we}, 0);

        // irregular grants, 5 words
        gmode = 1;
        wr(3'd0, 16'd5); wr(3'd1, 16'h1000); wr(3'd2, 16'h0002); wr(3'd3, 16'h0002);
        run_dma(5, 16'h0400, "irregular");

        // start commands that must not start anything
        wr(3'd5, 16'h0001);
        idle_window("B without A");
        wr(3'd4, 16'h0200); wr(3'd5, 16'h0000);
        idle_window("B with start bit clear");
        wr(3'd5, 16'h0001);
        idle_window("B after disarming B");

        // 32-bit style pair: trigger then held length write; dst wraps
        wr(3'd0, 16'd4); wr(3'd3, 16'h0020);
        push_exp(4, 16'hFFE0);
        we0 = we_cnt;
        wr(3'd4, 16'hFFE0);
        wr(3'd5, 16'h0001);
        cpu_write(3'd0, 16'd3, fw, acc_c);
        check(fw == 1'b1, "R7", "second half held", fw, 1);
        check(acc_c == last_we + 2, "R7", "held write lands at release",
              acc_c - last_we, 2);
        check(we_cnt - we0 == 4, "R7", "old length used", we_cnt - we0, 4);
        check(q_exp.size() == 0, "R4", "wrap sequence complete", q_exp.size(), 0);

        // sparse grants, new length 3 from the held write
        gmode = 2;
        run_dma(3, 16'h0100, "held length R7");

        // zero length means 65536 words
        gmode = 0;
        wr(3'd0, 16'd0); wr(3'd3, 16'h0001);
        run_dma(65536, 16'h0000, "zero length R5");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        while (pcyc < 190000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected=<190000", pcyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule